// File: doc/BRIEF.md
# EDH Error Flag Port Controller

This block is the host-side access port for the error flags of an EDH packet processor. An external controller uses a read/write strobe, a 2-bit group select and a 5-bit bidirectional flag bus to read or overwrite the error flags. The bus is carried as three separate nets: data in, data out and drive enable. All of it runs on the processor's internal parallel clock.

The block holds two banks of 15 error flags, one for the incoming packet and one for the outgoing packet. It also holds two validity bits and an IN/OUT select bit. The packet parser loads the incoming bank and the validity bits through a load strobe. The outgoing bank is changed only by the host. The checksum-error flag and the S status bit are live inputs from the processor and are only read. A read returns its data one clock after the select is sampled. The bus is released for one dead cycle when a write begins, and a write touches only the group it addresses.

Top module: `edh_flag_port`

## Requirements
- R1: After reset the bus is driven (`fl_oe_o` = 1). Both flag banks, both validity bits and IN/OUT are 0.
- R2: When the clock edge samples `rw_i` high, `fl_oe_o` is 1 after that edge. The select sampled at that edge has its data on `fl_out_o` after the following edge, so there is one clock of latency. Reads pipeline back to back, one per clock.
- R3: Selects 0, 1 and 2 return groups 0, 1 and 2. These are the full-field, active-picture and ancillary groups. Group g occupies bits 5g+4..5g of a 15-bit bank. Inside a group, bits 4..0 are UES, IDA, IDH, EDA and EDH.
- R4: IN/OUT = 1 selects the incoming bank and IN/OUT = 0 selects the outgoing bank. This choice applies both to reads and to host writes at selects 0–2.
- R5: A read at select 3 returns a status word. Bit 4 is the checksum-error input when IN/OUT = 0 and 0 otherwise. Bit 3 is the active-picture validity bit and bit 2 is the full-field validity bit, both taken from the incoming validity register whatever IN/OUT is. Bit 1 is the S input. Bit 0 is 0.
- R6: The first edge that samples `rw_i` low after a read only releases the bus. No register changes at that edge.
- R7: Each later edge with `rw_i` low writes `fl_in_i` into the group named by `sel_i`. All other groups keep their values.
- R8: A write at select 3 stores bit 3 as the active-picture validity, bit 2 as the full-field validity and bit 0 as IN/OUT. Bits 4 and 1 are ignored, and neither flag bank changes.
- R9: `fl_oe_o` is 0 after every edge that samples `rw_i` low. The bus is therefore never driven during turnaround or while a write is in progress.
- R10: `in_load_i` loads `in_flags_i` into the incoming bank and `in_valid_i` (bit 1 active-picture, bit 0 full-field) into the validity register. If a host write lands at the same edge, the host wins for the group or status word it addresses, and the load still updates everything else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rw_i | input | 1 | Strobe: 1 = read, 0 = write |
| sel_i | input | 2 | Group select |
| fl_in_i | input | 5 | Flag bus, input net |
| fl_out_o | output | 5 | Flag bus, output net |
| fl_oe_o | output | 1 | Flag bus drive enable |
| in_load_i | input | 1 | Parser load strobe for the incoming flags |
| in_flags_i | input | 15 | Incoming flags from the parser |
| in_valid_i | input | 2 | Incoming validity bits from the parser |
| chksum_err_i | input | 1 | Checksum-error flag |
| s_bit_i | input | 1 | S status bit |
| in_flags_o | output | 15 | Incoming flag bank |
| out_flags_o | output | 15 | Outgoing flag bank |
| valid_o | output | 2 | Validity bits (bit 1 AP, bit 0 FF) |
| inout_o | output | 1 | IN/OUT select bit |

## Verification
Both the parser load and a host write can update the incoming bank or the validity register at the same clock edge. The bench provokes this by setting IN/OUT to 1 and then driving `in_load_i` in the same cycle as a host write to group 1. It does the same again with a host write to the status select. The result is judged group by group on `in_flags_o` and `valid_o`: the addressed group must hold the host value and every other field must hold the parser value.

// File: rtl/edh_fp_pkg.sv
package edh_fp_pkg;
   // default geometry of the flag port
   localparam int FP_FL_W  = 5;
   localparam int FP_SEL_W = 2;
   localparam int FP_N_GRP = 3;

   // bit positions of the status word (select just above the last group)
   localparam int ST_CKS = 4;
   localparam int ST_APV = 3;
   localparam int ST_FFV = 2;
   localparam int ST_SB  = 1;
   localparam int ST_IO  = 0;

   // bus phase seen by the port
   typedef enum logic [1:0] {
      PH_READ  = 2'd0,
      PH_TURN  = 2'd1,
      PH_WRITE = 2'd2
   } phase_e;
endpackage

// File: rtl/edh_fp_bus_ctl.sv
module edh_fp_bus_ctl
   import edh_fp_pkg::*;
#(
   parameter int SEL_W = FP_SEL_W,
   parameter int FL_W  = FP_FL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rw_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic [FL_W-1:0]  fl_in_i,
   output logic             oe_o,
   output logic             wr_en_o,
   output logic [SEL_W-1:0] wr_sel_o,
   output logic [FL_W-1:0]  wr_data_o,
   output logic [SEL_W-1:0] rd_sel_o
);
   phase_e           phase_q, phase_d;
   logic [SEL_W-1:0] rd_sel_q;

   always_comb begin
      if (rw_i)                  phase_d = PH_READ;
      else if (phase_q == PH_READ) phase_d = PH_TURN;
      else                       phase_d = PH_WRITE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_READ;
         rd_sel_q <= '0;
      end else begin
         phase_q <= phase_d;
         if (rw_i) rd_sel_q <= sel_i;
      end
   end

   // the first low sample only releases the bus; later ones write
   assign wr_en_o   = !rw_i && (phase_q != PH_READ);
   assign wr_sel_o  = sel_i;
   assign wr_data_o = fl_in_i;
   assign oe_o      = (phase_q == PH_READ);
   assign rd_sel_o  = rd_sel_q;
endmodule

// File: rtl/edh_fp_flag_bank.sv
module edh_fp_flag_bank
   import edh_fp_pkg::*;
#(
   parameter  int FL_W   = FP_FL_W,
   parameter  int N_GRP  = FP_N_GRP,
   parameter  int SEL_W  = FP_SEL_W,
   localparam int BANK_W = FL_W * N_GRP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [SEL_W-1:0]  wr_sel_i,
   input  logic [FL_W-1:0]   wr_data_i,
   input  logic              ld_en_i,
   input  logic [BANK_W-1:0] ld_flags_i,
   input  logic [1:0]        ld_valid_i,
   output logic [BANK_W-1:0] in_flags_o,
   output logic [BANK_W-1:0] out_flags_o,
   output logic [1:0]        valid_o,
   output logic              inout_o
);
   localparam logic [SEL_W-1:0] STAT_SEL = SEL_W'(N_GRP);

   logic       inout_q;
   logic [1:0] valid_q;
   logic       stat_hit;

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      logic            hit;
      logic [FL_W-1:0] in_q, out_q;

      assign hit = wr_en_i && (wr_sel_i == SEL_W'(g));

      // incoming group: host write beats parser load
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                in_q <= '0;
         else if (hit && inout_q)   in_q <= wr_data_i;
         else if (ld_en_i)          in_q <= ld_flags_i[g*FL_W +: FL_W];
      end

      // outgoing group: host only
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                out_q <= '0;
         else if (hit && !inout_q)  out_q <= wr_data_i;
      end

      assign in_flags_o[g*FL_W +: FL_W]  = in_q;
      assign out_flags_o[g*FL_W +: FL_W] = out_q;
   end

   assign stat_hit = wr_en_i && (wr_sel_i == STAT_SEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         inout_q <= 1'b0;
      end else if (stat_hit) begin
         valid_q <= {wr_data_i[ST_APV], wr_data_i[ST_FFV]};
         inout_q <= wr_data_i[ST_IO];
      end else if (ld_en_i) begin
         valid_q <= ld_valid_i;
      end
   end

   assign valid_o = valid_q;
   assign inout_o = inout_q;
endmodule

// File: rtl/edh_fp_read_mux.sv
module edh_fp_read_mux
   import edh_fp_pkg::*;
#(
   parameter  int FL_W   = FP_FL_W,
   parameter  int N_GRP  = FP_N_GRP,
   parameter  int SEL_W  = FP_SEL_W,
   localparam int BANK_W = FL_W * N_GRP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  rd_sel_i,
   input  logic [BANK_W-1:0] in_flags_i,
   input  logic [BANK_W-1:0] out_flags_i,
   input  logic [1:0]        valid_i,
   input  logic              inout_i,
   input  logic              cks_i,
   input  logic              sbit_i,
   output logic [FL_W-1:0]   data_o
);
   localparam logic [SEL_W-1:0] STAT_SEL = SEL_W'(N_GRP);

   logic [FL_W-1:0] words [0:N_GRP];
   logic [FL_W-1:0] stat_w;
   logic [FL_W-1:0] data_q;

   for (genvar g = 0; g < N_GRP; g++) begin : g_word
      assign words[g] = inout_i ? in_flags_i[g*FL_W +: FL_W]
                                : out_flags_i[g*FL_W +: FL_W];
   end

   always_comb begin
      stat_w         = '0;
      stat_w[ST_CKS] = cks_i & ~inout_i;
      stat_w[ST_APV] = valid_i[1];
      stat_w[ST_FFV] = valid_i[0];
      stat_w[ST_SB]  = sbit_i;
   end
   assign words[N_GRP] = stat_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     data_q <= '0;
      else if (rd_sel_i <= STAT_SEL)  data_q <= words[rd_sel_i];
      else                            data_q <= '0;
   end

   assign data_o = data_q;
endmodule

// File: rtl/edh_flag_port.sv
module edh_flag_port
   import edh_fp_pkg::*;
#(
   parameter  int FL_W   = FP_FL_W,
   parameter  int N_GRP  = FP_N_GRP,
   parameter  int SEL_W  = FP_SEL_W,
   localparam int BANK_W = FL_W * N_GRP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rw_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [FL_W-1:0]   fl_in_i,
   output logic [FL_W-1:0]   fl_out_o,
   output logic              fl_oe_o,
   input  logic              in_load_i,
   input  logic [BANK_W-1:0] in_flags_i,
   input  logic [1:0]        in_valid_i,
   input  logic              chksum_err_i,
   input  logic              s_bit_i,
   output logic [BANK_W-1:0] in_flags_o,
   output logic [BANK_W-1:0] out_flags_o,
   output logic [1:0]        valid_o,
   output logic              inout_o
);
   if (FL_W < 5) begin : g_bad_width
      $error("flag port: FL_W must hold the five-bit status word");
   end
   if (N_GRP + 1 > (1 << SEL_W)) begin : g_bad_sel
      $error("flag port: SEL_W too narrow for groups plus status");
   end

   logic             wr_en;
   logic [SEL_W-1:0] wr_sel;
   logic [FL_W-1:0]  wr_data;
   logic [SEL_W-1:0] rd_sel;

   edh_fp_bus_ctl #(.SEL_W(SEL_W), .FL_W(FL_W)) i_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .rw_i      (rw_i),
      .sel_i     (sel_i),
      .fl_in_i   (fl_in_i),
      .oe_o      (fl_oe_o),
      .wr_en_o   (wr_en),
      .wr_sel_o  (wr_sel),
      .wr_data_o (wr_data),
      .rd_sel_o  (rd_sel)
   );

   edh_fp_flag_bank #(.FL_W(FL_W), .N_GRP(N_GRP), .SEL_W(SEL_W)) i_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (wr_en),
      .wr_sel_i    (wr_sel),
      .wr_data_i   (wr_data),
      .ld_en_i     (in_load_i),
      .ld_flags_i  (in_flags_i),
      .ld_valid_i  (in_valid_i),
      .in_flags_o  (in_flags_o),
      .out_flags_o (out_flags_o),
      .valid_o     (valid_o),
      .inout_o     (inout_o)
   );

   edh_fp_read_mux #(.FL_W(FL_W), .N_GRP(N_GRP), .SEL_W(SEL_W)) i_rmux (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_sel_i    (rd_sel),
      .in_flags_i  (in_flags_o),
      .out_flags_i (out_flags_o),
      .valid_i     (valid_o),
      .inout_i     (inout_o),
      .cks_i       (chksum_err_i),
      .sbit_i      (s_bit_i),
      .data_o      (fl_out_o)
   );
endmodule

// File: rtl/edh_flag_port_chk.sv
module edh_flag_port_chk
   import edh_fp_pkg::*;
#(
   parameter  int FL_W   = FP_FL_W,
   parameter  int N_GRP  = FP_N_GRP,
   parameter  int SEL_W  = FP_SEL_W,
   localparam int BANK_W = FL_W * N_GRP
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rw_i,
   input logic [SEL_W-1:0]  sel_i,
   input logic [FL_W-1:0]   fl_out_o,
   input logic              fl_oe_o,
   input logic              s_bit_i,
   input logic [BANK_W-1:0] out_flags_o,
   input logic [1:0]        valid_o,
   input logic              inout_o
);
   localparam logic [SEL_W-1:0] STAT_SEL = SEL_W'(N_GRP);

   AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      rw_i |=> fl_oe_o);                                               // R2

   AST_LOW_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !rw_i |=> !fl_oe_o);                                             // R9

   AST_TURN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rw_i) && !rw_i) |=> ($stable(out_flags_o) && $stable(inout_o) && $stable(valid_o))); // R6

   AST_STAT_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (!rw_i && !$past(rw_i) && sel_i == STAT_SEL) |=> $stable(out_flags_o)); // R8

   AST_STAT_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rw_i, 2) && $past(sel_i, 2) == STAT_SEL) |-> (fl_out_o[ST_IO] == 1'b0)); // R5

   AST_STAT_CKS_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rw_i, 2) && $past(sel_i, 2) == STAT_SEL && $past(inout_o)) |-> (fl_out_o[ST_CKS] == 1'b0)); // R5

   AST_STAT_VALID_S: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rw_i, 2) && $past(sel_i, 2) == STAT_SEL)
      |-> (fl_out_o[ST_APV:ST_FFV] == $past(valid_o) && fl_out_o[ST_SB] == $past(s_bit_i))); // R5
endmodule

bind edh_flag_port edh_flag_port_chk #(.FL_W(FL_W), .N_GRP(N_GRP), .SEL_W(SEL_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rw_i        (rw_i),
   .sel_i       (sel_i),
   .fl_out_o    (fl_out_o),
   .fl_oe_o     (fl_oe_o),
   .s_bit_i     (s_bit_i),
   .out_flags_o (out_flags_o),
   .valid_o     (valid_o),
   .inout_o     (inout_o)
);

// File: tb/test_edh_flag_port.sv
`timescale 1ns/1ps
module test_edh_flag_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rw = 1'b1;
   logic [1:0]  sel = 2'd0;
   logic [4:0]  fl_in = 5'd0;
   logic [4:0]  fl_out;
   logic        fl_oe;
   logic        in_load = 1'b0;
   logic [14:0] in_flags = 15'd0;
   logic [1:0]  in_valid = 2'd0;
   logic        cks = 1'b0;
   logic        sbit = 1'b0;
   logic [14:0] in_bank, out_bank;
   logic [1:0]  valid;
   logic        io;

   always #5 clk = ~clk;

   edh_flag_port i_edh_flag_port (
      .clk(clk), .rst_n(rst_n), .rw_i(rw), .sel_i(sel), .fl_in_i(fl_in),
      .fl_out_o(fl_out), .fl_oe_o(fl_oe), .in_load_i(in_load),
      .in_flags_i(in_flags), .in_valid_i(in_valid), .chksum_err_i(cks),
      .s_bit_i(sbit), .in_flags_o(in_bank), .out_flags_o(out_bank),
      .valid_o(valid), .inout_o(io)
   );

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // reference state kept from the requirements
   logic [14:0] m_in = '0, m_out = '0;
   logic [1:0]  m_val = '0;
   logic        m_io = 1'b0;

   typedef struct { logic [4:0] data; int due; string tag; } rd_item_t;
   rd_item_t sb[$];

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_read(input logic [1:0] s);
      logic [4:0] w;
      if (s == 2'd3) w = {cks & ~m_io, m_val[1], m_val[0], sbit, 1'b0};   // R5 layout
      else           w = m_io ? m_in[s*5 +: 5] : m_out[s*5 +: 5];          // R3 R4
      return w;
   endfunction

   // driver: issue one read and push its expected word
   task automatic rd(input logic [1:0] s, input string tag);
      rd_item_t it;
      @(negedge clk);
      rw = 1'b1; sel = s;
      it.data = exp_read(s); it.due = cyc + 2; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
   endtask

   // first low cycle: garbage on the bus must be ignored (R6)
   task automatic wr_begin(input logic [1:0] s, input logic [4:0] junk);
      @(negedge clk);
      rw = 1'b0; sel = s; fl_in = junk;
   endtask

   task automatic wr(input logic [1:0] s, input logic [4:0] d, input bit ld,
                     input logic [14:0] ldf, input logic [1:0] ldv);
      @(negedge clk);
      check(fl_oe == 1'b0, "R9 bus released during write", fl_oe, 0);
      rw = 1'b0; sel = s; fl_in = d;
      in_load = ld; in_flags = ldf; in_valid = ldv;
      if (ld) begin m_in = ldf; m_val = ldv; end
      if (s == 2'd3) begin m_val = {d[3], d[2]}; m_io = d[0]; end
      else if (m_io) m_in[s*5 +: 5] = d;
      else           m_out[s*5 +: 5] = d;
   endtask

   // monitor: compare read words when due
   always @(negedge clk) begin
      if (sb.size() != 0 && sb[0].due == cyc) begin
         rd_item_t it;
         it = sb.pop_front();
         check(fl_oe == 1'b1, {"R2 bus driven for ", it.tag}, fl_oe, 1);
         check(fl_out == it.data, it.tag, fl_out, it.data);
      end
   end

   initial begin
      #(200000 * 10);
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(fl_oe == 1'b1, "R1 bus driven after reset", fl_oe, 1);
      check(in_bank == 0 && out_bank == 0, "R1 banks clear", {in_bank, out_bank}, 0);
      check(valid == 0 && io == 0, "R1 valid/io clear", {valid, io}, 0);

      // R2 R3 R5: pipelined reads across all selects
      cks = 1'b1; sbit = 1'b1;
      for (int s = 0; s < 4; s++) rd(2'(s), "R2 R5 read after reset");
      drain();

      // R6 R7: junk at turnaround addressed to group 1, then write groups 0 and 2
      wr_begin(2'd1, 5'h1F);
      wr(2'd0, 5'h15, 0, '0, '0);
      wr(2'd2, 5'h1C, 0, '0, '0);
      @(negedge clk);
      check(out_bank == {5'h1C, 5'h00, 5'h15}, "R6 R7 out bank after writes", out_bank, {5'h1C, 5'h00, 5'h15});
      check(in_bank == 15'd0, "R4 in bank untouched with IN/OUT=0", in_bank, 0);
      for (int s = 0; s < 3; s++) rd(2'(s), "R3 R4 read out bank");
      drain();

      // R7: only group 1
      wr_begin(2'd0, 5'h00);
      wr(2'd1, 5'h0A, 0, '0, '0);
      @(negedge clk);
      check(out_bank == m_out, "R7 single group write", out_bank, m_out);

      // R10: parser load alone
      rw = 1'b1;
      in_load = 1'b1; in_flags = 15'h2A5B; in_valid = 2'b10;
      m_in = 15'h2A5B; m_val = 2'b10;
      @(negedge clk);
      in_load = 1'b0;
      check(in_bank == 15'h2A5B && valid == 2'b10, "R10 parser load", {in_bank, valid}, {15'h2A5B, 2'b10});

      // R6 R8: junk at turnaround on status select must not set IN/OUT
      wr_begin(2'd3, 5'h1F);
      @(negedge clk);
      check(io == 1'b0 && valid == 2'b10, "R6 turnaround ignored", {valid, io}, {2'b10, 1'b0});
      rw = 1'b1;
      wr_begin(2'd3, 5'h00);
      wr(2'd3, 5'b10111, 0, '0, '0);
      @(negedge clk);
      check(valid == 2'b01 && io == 1'b1, "R8 status write", {valid, io}, {2'b01, 1'b1});
      check(out_bank == m_out && in_bank == m_in, "R8 banks unchanged", {out_bank, in_bank}, {m_out, m_in});

      // R4 R5: reads now come from incoming bank; S follows input not the write
      for (int s = 0; s < 4; s++) rd(2'(s), "R4 R5 read in bank");
      drain();
      sbit = 1'b0;
      rd(2'd3, "R8 written bit1 ignored, R5 S bit");
      drain();

      // R10: concurrent host write and parser load
      wr_begin(2'd0, 5'h00);
      wr(2'd1, 5'h11, 1, 15'h7FFF, 2'b11);
      @(negedge clk);
      in_load = 1'b0;
      check(in_bank == {5'h1F, 5'h11, 5'h1F}, "R10 host wins its group", in_bank, {5'h1F, 5'h11, 5'h1F});
      check(valid == 2'b11, "R10 load updates validity", valid, 2'b11);
      check(out_bank == m_out, "R4 out bank untouched with IN/OUT=1", out_bank, m_out);
      rw = 1'b1;
      wr_begin(2'd0, 5'h00);
      wr(2'd3, 5'b01000, 1, 15'h0000, 2'b01);
      @(negedge clk);
      in_load = 1'b0;
      check(valid == 2'b10 && io == 1'b0, "R10 host wins status", {valid, io}, {2'b10, 1'b0});
      check(in_bank == 15'h0000, "R10 load updates other groups", in_bank, 0);

      // R5: IN/OUT=0 shows checksum flag
      cks = 1'b1; sbit = 1'b1;
      for (int s = 0; s < 4; s++) rd(2'(s), "R3 R5 final reads");
      drain();

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule